// File: doc/BRIEF.md
# Interframe Gap Timer

This block spaces out the repeated frames of one radio message. Software holds four settings through a small write port: an 8-bit base count, a 6-bit frame-time count, a 7-bit seed for a pseudo-random term, and a frame count. A send strobe starts a burst. The block pulses `frame_start` for the first frame at once. After each computed idle gap it pulses `frame_start` again, until the requested number of frames has been started.

Each gap is measured in ticks of the `tick` input, which marks one nominal millisecond. With a nonzero seed, the gap is the sum of three parts, consumed one after another: the base count, then the frame-time count, then the current value of a 7-bit LFSR. The LFSR advances once at the start of every gap. With a zero seed, the LFSR stays at zero, and the base and frame-time counts run down together, so the gap is the larger of the two. A synchronous reset clears every setting and all sequencing state.

Top module: `gap_timer`

## Requirements
- R1: While `srst` is high at a clock edge, all held settings, the LFSR and all sequencing state clear. After that edge `frame_start`, `busy`, `done` and `base_bad` are 0, and a send with no writes gives exactly one frame.
- R2: A write with `wr_en` high stores `wr_data` into the setting chosen by `wr_sel`. The codes and the bits taken are: 0 base (bits 7:0), 1 frame time (bits 5:0), 2 seed (bits 6:0), 3 frame count (bits 3:0).
- R3: `base_bad` is high exactly while the held base count is between 1 and 4 inclusive.
- R4: A send strobe seen while `busy` is low pulses `frame_start` for one cycle after that edge, and copies the seed into the working LFSR. A send strobe seen while `busy` is high has no effect.
- R5: With a nonzero seed, a gap lasts base + frame time + LFSR value ticks, consumed serially. The next `frame_start` is high in the second cycle after the edge that consumes the last count. A gap of zero counts pulses `frame_start` in the cycle right after the previous pulse.
- R6: The LFSR steps once at the start of each gap, as next = {v[5:0], v[6]^v[5]}. The first gap of a burst uses the step of the seed. A zero LFSR stays zero.
- R7: With a zero seed, the base and frame-time counts both decrement on each tick, so the gap equals the larger of the two.
- R8: A `tick` seen while idle, or a cycle without `tick`, consumes no count.
- R9: A frame count N ≥ 2 gives N `frame_start` pulses per burst, and 0 or 1 gives one pulse. `busy` is high between the first and last pulse. `done` rises with the last pulse and stays high until the next accepted send.
- R10: Writes made while `busy` is high do not change the burst in progress. They take effect from the next accepted send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Setting write enable |
| wr_sel | input | 2 | Setting select code |
| wr_data | input | 8 | Write data |
| send | input | 1 | Burst start strobe |
| tick | input | 1 | One-millisecond time tick |
| frame_start | output | 1 | One-cycle pulse per frame start |
| busy | output | 1 | Burst in progress, gaps pending |
| done | output | 1 | Last frame of the burst started |
| base_bad | output | 1 | Held base count is in the illegal range |

## Verification
The assertions check these behaviours on every cycle:
- the serial ordering of the count-down and the lockstep decrement in zero-seed mode;
- the LFSR holding at zero and never reaching zero from a nonzero state;
- the write path into the base setting;
- the frozen burst configuration while `busy` is high;
- `done` and `busy` never being high together.

Only the bench scenarios show whole gap lengths, which depend on the sum or the maximum of the counts. The same goes for the LFSR sequence across a burst, the frame count per send, sends and writes ignored during a burst, and ticks ignored while idle. A behavioural model checks all of these cycle by cycle.

// File: rtl/gap_pkg.sv
package gap_pkg;
    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_FT   = 2'd1,
        SEL_SEED = 2'd2,
        SEL_NFR  = 2'd3
    } reg_sel_e;

    localparam int BAD_LO = 1;
    localparam int BAD_HI = 4;
endpackage

// File: rtl/gap_regs.sv
module gap_regs
    import gap_pkg::*;
#(
    parameter int BW = 8,
    parameter int FW = 6,
    parameter int RW = 7,
    parameter int NW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [BW-1:0] base_o,
    output logic [FW-1:0] ft_o,
    output logic [RW-1:0] seed_o,
    output logic [NW-1:0] nfr_o,
    output logic          base_bad_o
);
    typedef struct packed {
        logic [BW-1:0] base;
        logic [FW-1:0] ft;
        logic [RW-1:0] seed;
        logic [NW-1:0] nfr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_BASE: cfg_d.base = wr_data[BW-1:0];
                SEL_FT:   cfg_d.ft   = wr_data[FW-1:0];
                SEL_SEED: cfg_d.seed = wr_data[RW-1:0];
                default:  cfg_d.nfr  = wr_data[NW-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (srst) cfg_q <= '0;
        else      cfg_q <= cfg_d;
    end

    assign base_o     = cfg_q.base;
    assign ft_o       = cfg_q.ft;
    assign seed_o     = cfg_q.seed;
    assign nfr_o      = cfg_q.nfr;
    assign base_bad_o = (cfg_q.base >= BW'(BAD_LO)) && (cfg_q.base <= BW'(BAD_HI));

    // R2: a base write lands in the held setting on the next edge
    assert_base_wr_R2: assert property (@(posedge clk) disable iff (srst)
        (wr_en && wr_sel == SEL_BASE) |=> (base_o == $past(wr_data[BW-1:0])));
endmodule

// File: rtl/gap_lfsr.sv
module gap_lfsr #(
    parameter int RW  = 7,
    parameter int TAP = 5
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          upd,
    input  logic          use_seed,
    input  logic [RW-1:0] seed,
    output logic [RW-1:0] step_o
);
    logic [RW-1:0] lfsr_d, lfsr_q, src;

    always_comb begin
        src    = use_seed ? seed : lfsr_q;
        step_o = {src[RW-2:0], src[RW-1] ^ src[TAP]};
        lfsr_d = upd ? step_o : lfsr_q;
    end

    always_ff @(posedge clk) begin
        if (srst) lfsr_q <= '0;
        else      lfsr_q <= lfsr_d;
    end

    // R6: a zero register stays zero when stepped
    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (srst)
        (upd && !use_seed && lfsr_q == '0) |=> (lfsr_q == '0));
    // R6: a nonzero register never steps into zero
    assert_stay_live_R6: assert property (@(posedge clk) disable iff (srst)
        (upd && !use_seed && lfsr_q != '0) |=> (lfsr_q != '0));
endmodule

// File: rtl/gap_count.sv
module gap_count #(
    parameter int BW = 8,
    parameter int FW = 6,
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          ld,
    input  logic          par,
    input  logic          tick,
    input  logic [BW-1:0] base,
    input  logic [FW-1:0] ft,
    input  logic [RW-1:0] rnd,
    output logic          zero_o
);
    typedef struct packed {
        logic [BW-1:0] base;
        logic [FW-1:0] ft;
        logic [RW-1:0] rnd;
        logic          par;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld) begin
            cnt_d.base = base;
            cnt_d.ft   = ft;
            cnt_d.rnd  = par ? '0 : rnd;
            cnt_d.par  = par;
        end else if (tick) begin
            if (cnt_q.par) begin
                if (cnt_q.base != '0) cnt_d.base = cnt_q.base - 1'b1;
                if (cnt_q.ft   != '0) cnt_d.ft   = cnt_q.ft - 1'b1;
            end else if (cnt_q.base != '0) begin
                cnt_d.base = cnt_q.base - 1'b1;
            end else if (cnt_q.ft != '0) begin
                cnt_d.ft = cnt_q.ft - 1'b1;
            end else if (cnt_q.rnd != '0) begin
                cnt_d.rnd = cnt_q.rnd - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (srst) cnt_q <= '0;
        else      cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q.base == '0) && (cnt_q.ft == '0) && (cnt_q.rnd == '0);

    // R5: in serial mode the later parts wait while the base part is nonzero
    assert_serial_order_R5: assert property (@(posedge clk) disable iff (srst)
        (!ld && !cnt_q.par && tick && cnt_q.base != '0)
        |=> ($stable(cnt_q.ft) && $stable(cnt_q.rnd)));
    // R7: in zero-seed mode both nonzero counts drop on the same tick
    assert_lockstep_R7: assert property (@(posedge clk) disable iff (srst)
        (!ld && cnt_q.par && tick && cnt_q.base != '0 && cnt_q.ft != '0)
        |=> (cnt_q.base == $past(cnt_q.base) - 1'b1 && cnt_q.ft == $past(cnt_q.ft) - 1'b1));
    // R8: no count moves without a tick or a load
    assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (srst)
        (!ld && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/gap_timer.sv
module gap_timer
    import gap_pkg::*;
#(
    parameter int BW  = 8,
    parameter int FW  = 6,
    parameter int RW  = 7,
    parameter int NW  = 4,
    parameter int DW  = 8,
    parameter int TAP = 5
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          send,
    input  logic          tick,
    output logic          frame_start,
    output logic          busy,
    output logic          done,
    output logic          base_bad
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic          fs;
        logic [NW-1:0] left;
        logic [BW-1:0] base_w;
        logic [FW-1:0] ft_w;
        logic          par_w;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [BW-1:0] base_r;
    logic [FW-1:0] ft_r;
    logic [RW-1:0] seed_r;
    logic [NW-1:0] nfr_r;
    logic [RW-1:0] step_val;
    logic          zero, accept, fire;
    logic          ld, upd, use_seed, ld_par;
    logic [BW-1:0] ld_base;
    logic [FW-1:0] ld_ft;
    logic [NW-1:0] rem;

    gap_regs #(.BW(BW), .FW(FW), .RW(RW), .NW(NW), .DW(DW)) u_regs (
        .clk(clk), .srst(srst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .base_o(base_r), .ft_o(ft_r), .seed_o(seed_r), .nfr_o(nfr_r),
        .base_bad_o(base_bad)
    );

    gap_lfsr #(.RW(RW), .TAP(TAP)) u_lfsr (
        .clk(clk), .srst(srst), .upd(upd), .use_seed(use_seed),
        .seed(seed_r), .step_o(step_val)
    );

    gap_count #(.BW(BW), .FW(FW), .RW(RW)) u_cnt (
        .clk(clk), .srst(srst), .ld(ld), .par(ld_par), .tick(tick & seq_q.busy),
        .base(ld_base), .ft(ld_ft), .rnd(step_val), .zero_o(zero)
    );

    assign accept = send && !seq_q.busy;
    assign fire   = seq_q.busy && zero;
    assign rem    = (nfr_r <= NW'(1)) ? '0 : nfr_r - 1'b1;

    always_comb begin
        seq_d    = seq_q;
        seq_d.fs = 1'b0;
        ld       = 1'b0;
        upd      = 1'b0;
        use_seed = accept;
        ld_base  = accept ? base_r : seq_q.base_w;
        ld_ft    = accept ? ft_r   : seq_q.ft_w;
        ld_par   = accept ? (seed_r == '0) : seq_q.par_w;
        if (accept) begin
            seq_d.fs     = 1'b1;
            seq_d.base_w = base_r;
            seq_d.ft_w   = ft_r;
            seq_d.par_w  = (seed_r == '0);
            seq_d.left   = rem;
            upd          = 1'b1;
            if (rem == '0) begin
                seq_d.done = 1'b1;
                seq_d.busy = 1'b0;
            end else begin
                seq_d.done = 1'b0;
                seq_d.busy = 1'b1;
                ld         = 1'b1;
            end
        end else if (fire) begin
            seq_d.fs = 1'b1;
            if (seq_q.left == NW'(1)) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.left = '0;
            end else begin
                seq_d.left = seq_q.left - 1'b1;
                ld         = 1'b1;
                upd        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (srst) seq_q <= '0;
        else      seq_q <= seq_d;
    end

    assign frame_start = seq_q.fs;
    assign busy        = seq_q.busy;
    assign done        = seq_q.done;

    // R9: completion and activity are exclusive
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (srst)
        done |-> !busy);
    // R10: the burst copy of the settings is frozen while busy
    assert_frozen_cfg_R10: assert property (@(posedge clk) disable iff (srst)
        busy |=> ($stable(seq_q.base_w) && $stable(seq_q.ft_w) && $stable(seq_q.par_w)));
    // R4: a send during a burst starts no new frame by itself
    assert_busy_send_R4: assert property (@(posedge clk) disable iff (srst)
        (busy && send && !zero) |=> !frame_start);
endmodule

// File: tb/sim_gap_timer.sv
`timescale 1ns/1ps
module sim_gap_timer;
    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       send = 1'b0;
    logic       tick = 1'b0;
    logic       frame_start, busy, done, base_bad;

    always #2 clk = ~clk;

    gap_timer u0 (
        .clk(clk), .srst(srst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .send(send), .tick(tick), .frame_start(frame_start), .busy(busy),
        .done(done), .base_bad(base_bad)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycno = 0;
    string tag = "R1";
    int fs_cyc[$];

    // behavioural reference model
    int m_base, m_ft, m_seed, m_nfr;
    int m_bw, m_fw, m_lfsr, m_left, m_gap;
    bit m_par, m_busy, m_done, m_fs;

    function automatic int stp(int v);
        int fb = ((v >> 6) ^ (v >> 5)) & 1;
        return ((v << 1) & 127) | fb;
    endfunction

    function automatic int gap_of();
        if (m_par) return (m_bw > m_fw) ? m_bw : m_fw;
        return m_bw + m_fw + m_lfsr;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycno);
        end
    endtask

    task automatic model_step();
        if (srst) begin
            m_base = 0; m_ft = 0; m_seed = 0; m_nfr = 0;
            m_bw = 0; m_fw = 0; m_lfsr = 0; m_left = 0; m_gap = 0;
            m_par = 0; m_busy = 0; m_done = 0; m_fs = 0;
        end else begin
            m_fs = 0;
            if (send && !m_busy) begin
                int rem;
                m_fs = 1; m_done = 0;
                m_lfsr = stp(m_seed);
                m_bw = m_base; m_fw = m_ft; m_par = (m_seed == 0);
                rem = (m_nfr <= 1) ? 0 : m_nfr - 1;
                m_left = rem;
                if (rem == 0) begin m_done = 1; m_busy = 0; end
                else begin m_busy = 1; m_gap = gap_of(); end
            end else if (m_busy && m_gap == 0) begin
                m_fs = 1;
                if (m_left == 1) begin m_busy = 0; m_done = 1; m_left = 0; end
                else begin m_left--; m_lfsr = stp(m_lfsr); m_gap = gap_of(); end
            end else if (m_busy && tick) begin
                m_gap--;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_base = wr_data;
                    2'd1: m_ft   = wr_data & 63;
                    2'd2: m_seed = wr_data & 127;
                    default: m_nfr = wr_data & 15;
                endcase
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        model_step();
        cycno++;
        if (frame_start) fs_cyc.push_back(cycno);
        chk(frame_start == m_fs, {tag, " frame_start"}, frame_start, m_fs);
        chk(busy == m_busy, {tag, " busy"}, busy, m_busy);
        chk(done == m_done, {tag, " done"}, done, m_done);
        chk(base_bad == (m_base >= 1 && m_base <= 4), "R3 base_bad", base_bad,
            (m_base >= 1 && m_base <= 4));
    endtask

    task automatic wr(int sel, int val);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(val);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic go();
        fs_cyc.delete();
        send = 1'b1; cyc(); send = 1'b0;
    endtask

    task automatic run_until_idle(int tick_every);
        for (int i = 0; i < 4000 && (busy || frame_start); i++) begin
            tick = (i % tick_every) == 0;
            cyc();
        end
        tick = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tag = "R1";
        cyc(); cyc();
        srst = 1'b0;
        chk(frame_start == 0 && busy == 0 && done == 0 && base_bad == 0,
            "R1 reset outputs", {frame_start, busy, done, base_bad}, 0);
        go(); cyc();
        chk(fs_cyc.size() == 1 && done == 1, "R1 single frame after reset", fs_cyc.size(), 1);

        tag = "R3";
        for (int v = 0; v < 7; v++) begin
            wr(0, v); cyc();
            chk(base_bad == (v >= 1 && v <= 4), "R3 range sweep", base_bad, (v >= 1 && v <= 4));
        end
        wr(0, 255); cyc();
        chk(base_bad == 0, "R2 R3 base 255 legal", base_bad, 0);

        tag = "R5 R6";
        wr(0, 5); wr(1, 8'hC3); wr(2, 8'h81); wr(3, 8'hF3);
        go();
        run_until_idle(1);
        chk(fs_cyc.size() == 3, "R9 three frames", fs_cyc.size(), 3);
        if (fs_cyc.size() == 3) begin
            chk(fs_cyc[1] - fs_cyc[0] == 11, "R5 R6 first serial gap", fs_cyc[1] - fs_cyc[0], 11);
            chk(fs_cyc[2] - fs_cyc[1] == 13, "R5 R6 second serial gap", fs_cyc[2] - fs_cyc[1], 13);
        end

        tag = "R6";
        wr(0, 0); wr(1, 0); wr(2, 64); wr(3, 3);
        go();
        run_until_idle(1);
        if (fs_cyc.size() == 3) begin
            chk(fs_cyc[1] - fs_cyc[0] == 2, "R6 seed 64 steps to 1", fs_cyc[1] - fs_cyc[0], 2);
            chk(fs_cyc[2] - fs_cyc[1] == 3, "R6 then steps to 2", fs_cyc[2] - fs_cyc[1], 3);
        end else chk(0, "R6 frame count", fs_cyc.size(), 3);

        tag = "R7";
        wr(0, 6); wr(1, 9); wr(2, 0); wr(3, 2);
        go();
        run_until_idle(1);
        if (fs_cyc.size() == 2)
            chk(fs_cyc[1] - fs_cyc[0] == 10, "R7 max of 6 and 9", fs_cyc[1] - fs_cyc[0], 10);
        else chk(0, "R7 frame count", fs_cyc.size(), 2);
        wr(0, 9); wr(1, 6);
        go();
        run_until_idle(1);
        if (fs_cyc.size() == 2)
            chk(fs_cyc[1] - fs_cyc[0] == 10, "R7 max of 9 and 6", fs_cyc[1] - fs_cyc[0], 10);
        else chk(0, "R7 frame count", fs_cyc.size(), 2);

        tag = "R8";
        for (int i = 0; i < 10; i++) begin tick = 1'b1; cyc(); end
        tick = 1'b0;
        chk(busy == 0 && frame_start == 0, "R8 idle ticks ignored", busy, 0);
        wr(0, 5); wr(1, 2); wr(2, 3); wr(3, 4);
        go();
        run_until_idle(3);
        chk(fs_cyc.size() == 4, "R8 R9 sparse ticks four frames", fs_cyc.size(), 4);

        tag = "R4 R10";
        wr(0, 5); wr(1, 0); wr(2, 0); wr(3, 2);
        go();
        tick = 1'b1; cyc(); cyc();
        tick = 1'b0;
        wr(0, 20); wr(3, 5);
        send = 1'b1; cyc(); send = 1'b0;
        chk(busy == 1 && frame_start == 0, "R4 send while busy ignored", frame_start, 0);
        run_until_idle(1);
        chk(fs_cyc.size() == 2, "R10 frame count frozen", fs_cyc.size(), 2);
        go();
        run_until_idle(1);
        chk(fs_cyc.size() == 5, "R10 new count after send", fs_cyc.size(), 5);
        if (fs_cyc.size() == 5)
            chk(fs_cyc[1] - fs_cyc[0] == 21, "R10 new base after send", fs_cyc[1] - fs_cyc[0], 21);

        tag = "R9";
        wr(3, 0);
        go(); cyc();
        chk(fs_cyc.size() == 1 && done == 1, "R9 count zero one frame", fs_cyc.size(), 1);
        wr(0, 0); wr(1, 0); wr(3, 3);
        go(); cyc(); cyc(); cyc();
        chk(fs_cyc.size() == 3, "R5 R9 zero gaps back to back", fs_cyc.size(), 3);
        if (fs_cyc.size() == 3)
            chk(fs_cyc[1] - fs_cyc[0] == 1, "R5 zero gap spacing", fs_cyc[1] - fs_cyc[0], 1);

        tag = "R1";
        wr(0, 3); wr(2, 5);
        srst = 1'b1; cyc(); srst = 1'b0; cyc();
        chk(base_bad == 0 && busy == 0 && done == 0, "R1 reset clears settings", base_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule